// File: doc/BRIEF.md
# Input-Capture Event Timer

This block is an 8-bit up-counter that sits on a 4-bit processor bus. The count is loaded, read and controlled through nibble-wide registers. The timer runs in one of three ways:

- **Free-running:** the count wraps past its top value.
- **Reload:** the count restarts from a programmed value on overflow.
- **Input capture:** a chosen edge on an asynchronous event pin freezes the current count into a read register, raises a status flag and an interrupt pulse, and restarts counting from zero. A second edge, or an overflow, that arrives before software has cleared the status flag marks the result as overrun in a separate error flag.

Counting is paced by a prescaler on the system clock, or by an external tick pulse. A mode register selects the pace and the overflow behaviour. A write to the mode register is staged, so the new mode takes effect only in the second cycle after the write. The 8-bit values travel as two nibbles:

- **Writes:** the low half is buffered, and writing the high half commits the full byte.
- **Reads:** reading the low half freezes the high half, so the two reads return one coherent sample.

Top module: `evcap_timer`

## Requirements
- R1: In capture mode a selected event edge copies the count into the capture register, clears the count and the prescaler to zero, and counting resumes; with edges D cycles apart and division 2^p the captured value is floor((D-1)/2^p).
- R2: A capture sets status bit 0 (address 4) and produces a one-cycle pulse on `irq_set`.
- R3: While status bit 0 is set, another capture edge or a counter overflow sets the error flag, status bit 1.
- R4: Writing address 4 clears status bit 0 when data bit 0 is 0 and clears bit 1 when data bit 1 is 0; a 1 leaves that bit unchanged; reset clears both.
- R5: Writing control address 1 with bit 0 = 1 enters capture mode: the count and prescaler clear, `pin_is_port` goes high, and counting uses the internal prescaler regardless of the mode source bit.
- R6: Mode register (address 0, write-only, reset 0) fields: bit 0 = reload on overflow, bits 2:1 = n for division by 2^n, bit 3 = count on `ext_tick` instead of the prescaler.
- R7: A mode written in cycle N governs counting from cycle N+2; edges N and N+1 still use the previous mode.
- R8: On overflow from 0xFF the count becomes 0x00 in free-running mode or the committed write value in reload mode, and `irq_set` pulses.
- R9: The event pin passes through two synchronizer flops; `evt_edge_sel` bit 0 enables rising edges and bit 1 falling edges; edges outside capture mode have no effect.
- R10: A write to address 2 buffers the low nibble; a write to address 3 commits {data, buffered low} into both the counter and the reload value.
- R11: A read of address 2 with `bus_rd` high returns the low nibble of the count (of the capture register in capture mode) and latches its high nibble; address 3 returns that latched nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe, latches the high half when reading address 2 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble, combinational from the address |
| evt_in | input | 1 | Asynchronous event pin |
| evt_edge_sel | input | 2 | Edge enables: bit 0 rising, bit 1 falling |
| ext_tick | input | 1 | External count pulse, one clock wide per count |
| irq_set | output | 1 | One-cycle interrupt request pulse |
| pin_is_port | output | 1 | High while capture mode returns the shared pin to port use |

## Verification
The bench concentrates on the following corner cases:

- **Mode staging:** it writes a new mode on the cycle right after a counter load. A design that applies the mode at once or one cycle early ends with a count of 0 or 1 instead of 2.
- **Captured values:** it compares captured values across known edge spacings, prescaler ratios, falling and double-edge selection, and capture-mode entry. A counter or prescaler that is not restarted on capture yields wrong or phase-dependent values.
- **Error flag:** it provokes the error flag both by a second edge and by a 256-cycle overflow, and it writes ones to the status register. A design that ignores overruns, or clears flags on a write of 1, shows the wrong status.
- **Coherent reads:** it reads a count that crosses a nibble boundary between the two reads. A read path without the high-half latch returns a torn value.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int NIB_W    = 4;
  localparam int PS_SEL_W = 2;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 3'd0,
    A_CTRL = 3'd1,
    A_DLO  = 3'd2,
    A_DHI  = 3'd3,
    A_STAT = 3'd4
  } addr_e;

  typedef struct packed {
    logic                ext_src;
    logic [PS_SEL_W-1:0] div_sel;
    logic                reload;
  } mode_t;
endpackage

// File: rtl/evcap_edge.sv
module evcap_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  always_comb begin
    rise = sync_q[STAGES-1] & ~prev_q;
    fall = ~sync_q[STAGES-1] & prev_q;
    hit  = (sel[0] & rise) | (sel[1] & fall);
  end
endmodule

// File: rtl/evcap_prescale.sv
module evcap_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sel));
    tick  = ((pre_q & mask) == mask);
    pre_d = clr ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/evcap_timer.sv
module evcap_timer
  import evcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              evt_in,
  input  logic [1:0]        evt_edge_sel,
  input  logic              ext_tick,
  output logic              irq_set,
  output logic              pin_is_port
);
  localparam int CNT_W = 2 * NIB_W;

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  mode_t            mode_pend_q, mode_eff_q;
  logic             cap_en_q, cap_en_d;
  logic [NIB_W-1:0] lo_buf_q, lo_buf_d, hi_lat_q, hi_lat_d;
  logic [CNT_W-1:0] reload_q, reload_d, cnt_q, cnt_d, cap_q, cap_d, rd_src;
  logic             sts_q, sts_d, err_q, err_d, irq_q, irq_d;
  logic             mode_wr, ctrl_wr, lo_wr, cnt_load, stat_wr, lo_rd;
  logic             enter, hit, cap_evt, int_tick, tick, ovf, pre_clr;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  evcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .din(evt_in), .sel(evt_edge_sel), .hit(hit)
  );

  evcap_prescale #(.SEL_W(PS_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .clr(pre_clr), .sel(mode_eff_q.div_sel),
    .tick(int_tick)
  );

  always_comb begin
    mode_wr  = bus_wr && (bus_addr == A_MODE);
    ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    lo_wr    = bus_wr && (bus_addr == A_DLO);
    cnt_load = bus_wr && (bus_addr == A_DHI);
    stat_wr  = bus_wr && (bus_addr == A_STAT);
    lo_rd    = bus_rd && (bus_addr == A_DLO);
    enter    = ctrl_wr && bus_wdata[0] && !cap_en_q;
    cap_evt  = cap_en_q && hit;
    // capture mode always paces from the internal prescaler
    tick     = (cap_en_q || !mode_eff_q.ext_src) ? int_tick : ext_tick;
    ovf      = tick && (cnt_q == {CNT_W{1'b1}});
    pre_clr  = cap_evt || cnt_load || enter;
    rd_src   = cap_en_q ? cap_q : cnt_q;
  end

  // next-state logic
  always_comb begin
    cap_en_d = ctrl_wr ? bus_wdata[0] : cap_en_q;
    lo_buf_d = lo_wr ? bus_wdata : lo_buf_q;
    reload_d = cnt_load ? {bus_wdata, lo_buf_q} : reload_q;
    hi_lat_d = lo_rd ? rd_src[CNT_W-1:NIB_W] : hi_lat_q;
    cap_d    = cap_evt ? cnt_q : cap_q;

    if (cnt_load)              cnt_d = {bus_wdata, lo_buf_q};
    else if (enter || cap_evt) cnt_d = '0;
    else if (ovf)              cnt_d = (mode_eff_q.reload && !cap_en_q) ? reload_q : '0;
    else if (tick)             cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;

    sts_d = sts_q;
    if (stat_wr && !bus_wdata[0]) sts_d = 1'b0;
    if (cap_evt)                  sts_d = 1'b1;

    err_d = err_q;
    if (stat_wr && !bus_wdata[1])   err_d = 1'b0;
    if (sts_q && (cap_evt || ovf))  err_d = 1'b1;

    irq_d = cap_evt || ovf;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_pend_q <= '0;
      mode_eff_q  <= '0;
      cap_en_q    <= 1'b0;
      lo_buf_q    <= '0;
      reload_q    <= '0;
      hi_lat_q    <= '0;
      cap_q       <= '0;
      cnt_q       <= '0;
      sts_q       <= 1'b0;
      err_q       <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (mode_wr) mode_pend_q <= mode_t'(bus_wdata);
      mode_eff_q <= mode_pend_q;
      cap_en_q   <= cap_en_d;
      lo_buf_q   <= lo_buf_d;
      reload_q   <= reload_d;
      hi_lat_q   <= hi_lat_d;
      cap_q      <= cap_d;
      cnt_q      <= cnt_d;
      sts_q      <= sts_d;
      err_q      <= err_d;
      irq_q      <= irq_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(NIB_W-1){1'b0}}, cap_en_q};
      A_DLO:   bus_rdata = rd_src[NIB_W-1:0];
      A_DHI:   bus_rdata = hi_lat_q;
      A_STAT:  bus_rdata = {{(NIB_W-2){1'b0}}, err_q, sts_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_set     = irq_q;
  assign pin_is_port = cap_en_q;
endmodule

// File: rtl/evcap_checker.sv
module evcap_checker #(
  parameter int CNT_W  = 8,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_evt,
  input logic              cnt_load,
  input logic              ovf,
  input logic              cap_sts,
  input logic              cap_err,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              mode_wr,
  input logic [MODE_W-1:0] mode_eff,
  input logic              stat_wr,
  input logic [1:0]        stat_wd
);
  AST_CAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !cnt_load) |=> (cnt == '0)); // R1
  AST_CAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_sts && irq)); // R2
  AST_ERR_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_err) |-> $past(cap_sts && (cap_evt || ovf))); // R3
  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_sts) |-> $past(stat_wr && !stat_wd[0])); // R4
  AST_MODE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff != $past(mode_eff)) |-> $past(mode_wr, 2)); // R7
  AST_OVF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq); // R8
endmodule

bind evcap_timer evcap_checker #(.CNT_W(CNT_W), .MODE_W(NIB_W)) i_chk (
  .clk(clk), .rst_n(rst_n_s), .cap_evt(cap_evt), .cnt_load(cnt_load),
  .ovf(ovf), .cap_sts(sts_q), .cap_err(err_q), .irq(irq_q), .cnt(cnt_q),
  .mode_wr(mode_wr), .mode_eff(mode_eff_q), .stat_wr(stat_wr),
  .stat_wd(bus_wdata[1:0])
);

// File: tb/test_evcap_timer.sv
module test_evcap_timer;
  import evcap_pkg::*;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk, rst_n, bus_wr, bus_rd, evt_in, ext_tick;
  logic [2:0] bus_addr;
  logic [3:0] bus_wdata, bus_rdata;
  logic [1:0] evt_edge_sel;
  logic       irq_set, pin_is_port;

  evcap_timer i_evcap_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .evt_edge_sel(evt_edge_sel), .ext_tick(ext_tick),
    .irq_set(irq_set), .pin_is_port(pin_is_port)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  item_t it;
  logic  mon_go = 1'b0;
  int    n_chk = 0, n_fail = 0, irq_cnt = 0, irq0;
  bit    done = 1'b0;

  // monitor: pops an expected item whenever the driver presents a read
  always @(negedge clk) begin
    #1;
    if (mon_go && q.size() > 0) begin
      it = q.pop_front();
      n_chk++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  always @(negedge clk) if (irq_set === 1'b1) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic lat, input logic [3:0] e,
                    input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = lat;
    q.push_back('{e, tag});
    mon_go = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; mon_go = 1'b0;
  endtask

  // two edges of the same kind spaced d cycles apart (pulses 3 cycles wide)
  task automatic cap_interval(input int d, input bit clr);
    fork
      begin
        @(negedge clk); evt_in = ~evt_in;
        repeat (3) @(negedge clk); evt_in = ~evt_in;
        repeat (d - 3) @(negedge clk); evt_in = ~evt_in;
        repeat (3) @(negedge clk); evt_in = ~evt_in;
      end
      begin
        if (clr) begin
          repeat (8) @(negedge clk);
          wr(A_STAT, 4'h0);
        end
      end
    join
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_in = 1'b0; evt_edge_sel = 2'b01; ext_tick = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(A_STAT, 1'b0, 4'h0, "R4 reset status");
    rd(A_CTRL, 1'b0, 4'h0, "R5 reset control");
    chk("R5 reset pin_is_port", int'(pin_is_port), 0);
    chk("R2 reset irq_set", int'(irq_set), 0);

    // R10/R11: load 0x2E, read across the nibble carry
    wr(A_DLO, 4'hE); wr(A_DHI, 4'h2);
    rd(A_DLO, 1'b1, 4'hF, "R11 low read");
    rd(A_DHI, 1'b0, 4'h2, "R11 latched high");

    // R7: mode to divide-by-8 on the cycle after a load
    wr(A_DLO, 4'h0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_DHI;  bus_wdata = 4'h0;
    @(negedge clk); bus_addr = A_MODE; bus_wdata = 4'b0110;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_DLO, 1'b1, 4'h2, "R7 staged mode");
    rd(A_DHI, 1'b0, 4'h0, "R7 staged mode high");

    // R6: external tick source
    wr(A_MODE, 4'b1000); repeat (3) @(negedge clk);
    wr(A_DLO, 4'h0); wr(A_DHI, 4'h1);
    repeat (10) @(negedge clk);
    rd(A_DLO, 1'b1, 4'h0, "R6 ext source holds");
    rd(A_DHI, 1'b0, 4'h1, "R6 ext source holds high");
    @(negedge clk); ext_tick = 1'b1;
    repeat (3) @(negedge clk); ext_tick = 1'b0;
    rd(A_DLO, 1'b1, 4'h3, "R6 ext ticks counted");

    // R8: reload and free-running overflow
    wr(A_MODE, 4'b0001); repeat (3) @(negedge clk);
    wr(A_DLO, 4'h0); irq0 = irq_cnt; wr(A_DHI, 4'hF);
    repeat (20) @(negedge clk);
    rd(A_DLO, 1'b1, 4'h5, "R8 reload low");
    rd(A_DHI, 1'b0, 4'hF, "R8 reload high");
    chk("R8 overflow irq", irq_cnt - irq0, 1);
    wr(A_MODE, 4'b0000); repeat (3) @(negedge clk);
    wr(A_DLO, 4'h0); wr(A_DHI, 4'hF);
    repeat (20) @(negedge clk);
    rd(A_DLO, 1'b1, 4'h5, "R8 wrap low");
    rd(A_DHI, 1'b0, 4'h0, "R8 wrap high");

    // R9: edges outside capture mode are ignored
    cap_interval(10, 1'b0);
    rd(A_STAT, 1'b0, 4'h0, "R9 edge ignored outside capture");

    // R5: entering capture clears the count; internal clock despite ext bit
    wr(A_MODE, 4'b1000); repeat (3) @(negedge clk);
    wr(A_STAT, 4'h0);
    irq0 = irq_cnt;
    wr(A_CTRL, 4'h1);
    evt_in = 1'b1;
    chk("R5 pin_is_port in capture", int'(pin_is_port), 1);
    repeat (6) @(negedge clk); evt_in = 1'b0;
    rd(A_DLO, 1'b1, 4'h2, "R5 capture after entry low");
    rd(A_DHI, 1'b0, 4'h0, "R5 capture after entry high");
    chk("R2 capture irq pulse", irq_cnt - irq0, 1);
    rd(A_STAT, 1'b0, 4'h1, "R2 status set");

    // R1: interval 40 at divide-by-1
    wr(A_MODE, 4'b0000); repeat (3) @(negedge clk);
    cap_interval(40, 1'b1);
    rd(A_DLO, 1'b1, 4'h7, "R1 interval low");
    rd(A_DHI, 1'b0, 4'h2, "R1 interval high");
    rd(A_STAT, 1'b0, 4'h1, "R3 no error after clear");

    // R6: divide-by-4, interval 30 -> 7
    wr(A_MODE, 4'b0100); repeat (3) @(negedge clk);
    cap_interval(30, 1'b1);
    rd(A_DLO, 1'b1, 4'h7, "R6 prescale low");
    rd(A_DHI, 1'b0, 4'h0, "R6 prescale high");

    // R9: falling edges, then both edges
    wr(A_MODE, 4'b0000); repeat (3) @(negedge clk);
    evt_edge_sel = 2'b10;
    cap_interval(20, 1'b1);
    rd(A_DLO, 1'b1, 4'h3, "R9 falling low");
    rd(A_DHI, 1'b0, 4'h1, "R9 falling high");
    evt_edge_sel = 2'b11;
    cap_interval(20, 1'b1);
    rd(A_DLO, 1'b1, 4'h2, "R9 both edges low");
    rd(A_DHI, 1'b0, 4'h0, "R9 both edges high");

    // R3: second edge before clear
    evt_edge_sel = 2'b01;
    wr(A_STAT, 4'h0);
    cap_interval(25, 1'b0);
    rd(A_DLO, 1'b1, 4'h8, "R3 overrun capture low");
    rd(A_DHI, 1'b0, 4'h1, "R3 overrun capture high");
    rd(A_STAT, 1'b0, 4'h3, "R3 overrun error");

    // R4: writing ones keeps, zeros clear per bit
    wr(A_STAT, 4'h3);
    rd(A_STAT, 1'b0, 4'h3, "R4 write ones no effect");
    wr(A_STAT, 4'h2);
    rd(A_STAT, 1'b0, 4'h2, "R4 clear status only");
    wr(A_STAT, 4'h0);
    rd(A_STAT, 1'b0, 4'h0, "R4 clear both");

    // R3: overflow while status pending
    @(negedge clk); evt_in = 1'b1;
    repeat (3) @(negedge clk); evt_in = 1'b0;
    repeat (100) @(negedge clk);
    rd(A_STAT, 1'b0, 4'h1, "R3 no overflow yet");
    repeat (200) @(negedge clk);
    rd(A_STAT, 1'b0, 4'h3, "R3 overflow error");

    // R5: leaving capture mode
    wr(A_CTRL, 4'h0);
    chk("R5 pin_is_port after exit", int'(pin_is_port), 0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule